// File: doc/BRIEF.md
# I/Q Word De-interleaver and Pair Aligner

This block takes a single data bus on which in-phase (I) and quadrature (Q) samples arrive one after another, and splits them into two parallel lanes. Each word that is written is steered by a channel-select input into either the I holding register or the Q holding register. The lanes then feed a pair of interpolation filters. Each lane therefore runs at half the write rate when words arrive on every clock, which is the case when the write strobe is tied high.

A small pairing state machine records which channel is currently waiting for its partner. A pair is released only when the partner word arrives. The released I and Q words appear together on the two output lanes with a one-cycle valid pulse, so the filters never see a Q word paired with the wrong I word. A second word for the channel that is already waiting replaces the held word and raises a one-cycle error flag. A combined sleep/reset input discards any half-built pair and clears both holding registers. While it is asserted, the input bus is ignored and the output lanes are frozen.

The asynchronous active-low reset is released synchronously inside the block. Everything else is sampled on the rising clock edge.

Top module: `iq_split_top`

## Requirements
- R1: While reset is active and after it is released, `pair_vld` and `dup_err` are 0 and `i_out`/`q_out` are all zeros.
- R2: A word written with `sel_q`=0 belongs to the I lane and one written with `sel_q`=1 belongs to the Q lane. Each released pair puts the I word on `i_out` and the Q word on `q_out`, whichever of the two arrived first.
- R3: `pair_vld` is high for exactly one cycle. That cycle is the one after the clock edge that captured the partner word, and `i_out`/`q_out` carry the pair in that same cycle.
- R4: A lone word with no partner never produces `pair_vld`, however many idle cycles follow it.
- R5: A second write to the channel that is already waiting replaces the held word and raises `dup_err` for one cycle, in the cycle after that write. The later pair carries the newest word.
- R6: While `wr_en`=0, the values on `din` and `sel_q` have no effect.
- R7: While `sleep_rst`=1, writes are ignored, `pair_vld` and `dup_err` stay 0 in the following cycle, and `i_out`/`q_out` hold their values. A word written before sleep is discarded and does not pair with a word written after it.
- R8: `i_out` and `q_out` change only in a cycle in which `pair_vld` is 1.
- R9: With `wr_en` held high and `sel_q` alternating every cycle, a pair is released every second cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_rst | input | 1 | Sleep/reset request: clears the pairing logic and freezes the outputs |
| wr_en | input | 1 | Write strobe, sampled on each rising edge |
| sel_q | input | 1 | Channel select for the word on `din`: 0 = I, 1 = Q |
| din | input | 10 | Interleaved data word |
| i_out | output | 10 | I word of the last released pair |
| q_out | output | 10 | Q word of the last released pair |
| pair_vld | output | 1 | One-cycle pulse marking a new aligned pair |
| dup_err | output | 1 | One-cycle flag: a waiting word was overwritten |

## Verification
The assertions assume that `sleep_rst`, `wr_en`, `sel_q` and `din` are synchronous to `clk` and settle well before each rising edge. They also assume that `rst_n` is held low long enough for the internal release synchronizer to flush. The bench changes every input 1 ns after a rising edge and samples the outputs 1 ns after the next edge. It holds reset for several cycles and waits out the release stages before checking anything. Random traffic mixes idle cycles, same-channel repeats and short sleep bursts, so every transition of the pairing state machine is reached.

// File: rtl/iq_split_pkg.sv
package iq_split_pkg;
  typedef enum logic [1:0] {
    PS_EMPTY  = 2'b00,
    PS_HAVE_I = 2'b01,
    PS_HAVE_Q = 2'b10
  } pair_st_e;

  localparam int unsigned LANE_I = 0;
  localparam int unsigned LANE_Q = 1;
  localparam int unsigned NUM_LANES = 2;
endpackage

// File: rtl/iq_rst_sync.sv
module iq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = shreg[STAGES-1];
endmodule

// File: rtl/iq_hold_reg.sv
module iq_hold_reg #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (clr)     q_nxt = '0;
    else if (en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  // R7: sleep request empties the holding register
  p_sleep_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q == '0));
endmodule

// File: rtl/iq_pair_fsm.sv
module iq_pair_fsm
  import iq_split_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sleep,
  input  logic wr,
  input  logic sel_q,
  output logic release_pair,
  output logic dup_hit
);
  pair_st_e st, st_nxt;

  always_comb begin
    st_nxt       = st;
    release_pair = 1'b0;
    dup_hit      = 1'b0;
    if (sleep) begin
      st_nxt = PS_EMPTY;
    end else if (wr) begin
      case (st)
        PS_EMPTY:  st_nxt = sel_q ? PS_HAVE_Q : PS_HAVE_I;
        PS_HAVE_I: begin
          if (sel_q) begin
            release_pair = 1'b1;
            st_nxt       = PS_EMPTY;
          end else begin
            dup_hit = 1'b1;
          end
        end
        PS_HAVE_Q: begin
          if (!sel_q) begin
            release_pair = 1'b1;
            st_nxt       = PS_EMPTY;
          end else begin
            dup_hit = 1'b1;
          end
        end
        default:   st_nxt = PS_EMPTY;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= PS_EMPTY;
    else        st <= st_nxt;
  end

  // R2: the waiting-channel code is never both channels at once
  p_state_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(st));
  // R5: a repeated I word keeps the block waiting for Q
  p_dup_keeps_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && wr && !sel_q && st == PS_HAVE_I) |=> (st == PS_HAVE_I));
  // R4: after a release nothing is left waiting
  p_release_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
    release_pair |=> (st == PS_EMPTY));
endmodule

// File: rtl/iq_out_stage.sv
module iq_out_stage #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         err_in,
  input  logic [W-1:0] i_in,
  input  logic [W-1:0] q_in,
  output logic [W-1:0] i_out,
  output logic [W-1:0] q_out,
  output logic         vld,
  output logic         err
);
  logic [W-1:0] i_nxt, q_nxt;

  always_comb begin
    i_nxt = i_out;
    q_nxt = q_out;
    if (load) begin
      i_nxt = i_in;
      q_nxt = q_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      i_out <= '0;
      q_out <= '0;
      vld   <= 1'b0;
      err   <= 1'b0;
    end else begin
      i_out <= i_nxt;
      q_out <= q_nxt;
      vld   <= load;
      err   <= err_in;
    end
  end

  // R3: valid is a single-cycle pulse
  p_vld_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vld |=> !vld);
  // R8: lanes move only together with valid
  p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !vld |-> $stable({i_out, q_out}));
  // R5: error and valid never coincide
  p_err_vld_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(vld && err));
endmodule

// File: rtl/iq_split_top.sv
module iq_split_top
  import iq_split_pkg::*;
#(
  parameter int unsigned DW         = 10,
  parameter int unsigned SYNC_STAGE = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sleep_rst,
  input  logic          wr_en,
  input  logic          sel_q,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] i_out,
  output logic [DW-1:0] q_out,
  output logic          pair_vld,
  output logic          dup_err
);
  logic          rst_s_n;
  logic          wr_live;
  logic          rel, dup;
  logic [DW-1:0] held [NUM_LANES];
  logic [DW-1:0] lane_src [NUM_LANES];

  iq_rst_sync #(.STAGES(SYNC_STAGE)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n)
  );

  assign wr_live = wr_en && !sleep_rst;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    localparam logic LANE_SEL = (g == LANE_Q);
    logic lane_wr;
    assign lane_wr = wr_live && (sel_q == LANE_SEL);

    iq_hold_reg #(.W(DW)) u_hold (
      .clk(clk), .rst_n(rst_s_n), .clr(sleep_rst),
      .en(lane_wr), .d(din), .q(held[g])
    );

    // the completing word is taken straight from the bus
    assign lane_src[g] = lane_wr ? din : held[g];
  end

  iq_pair_fsm u_fsm (
    .clk(clk), .rst_n(rst_s_n), .sleep(sleep_rst),
    .wr(wr_en), .sel_q(sel_q),
    .release_pair(rel), .dup_hit(dup)
  );

  iq_out_stage #(.W(DW)) u_out (
    .clk(clk), .rst_n(rst_s_n), .load(rel), .err_in(dup),
    .i_in(lane_src[LANE_I]), .q_in(lane_src[LANE_Q]),
    .i_out(i_out), .q_out(q_out), .vld(pair_vld), .err(dup_err)
  );

  // R4: a pair only follows an accepted write
  p_vld_after_write_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    pair_vld |-> $past(wr_en && !sleep_rst));
  // R7: sleep silences both pulses
  p_sleep_quiet_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    sleep_rst |=> (!pair_vld && !dup_err));
  // R6: without a strobe neither pulse can follow
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    !wr_en |=> (!pair_vld && !dup_err));
endmodule

// File: tb/iq_split_top_tb.sv
module iq_split_top_tb;
  localparam int DW = 10;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sleep_rst, wr_en, sel_q;
  logic [DW-1:0] din;
  logic [DW-1:0] i_out, q_out;
  logic          pair_vld, dup_err;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // reference model state: 0 empty, 1 I waiting, 2 Q waiting
  int            m_st;
  logic [DW-1:0] m_hi, m_hq, e_i, e_q;
  logic          e_vld, e_err;

  always #2.5 clk = ~clk;

  iq_split_top u_dut (
    .clk(clk), .rst_n(rst_n), .sleep_rst(sleep_rst), .wr_en(wr_en),
    .sel_q(sel_q), .din(din), .i_out(i_out), .q_out(q_out),
    .pair_vld(pair_vld), .dup_err(dup_err)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model(input bit slp, input bit wr, input bit sq, input logic [DW-1:0] d);
    e_vld = 0;
    e_err = 0;
    if (slp) begin
      m_st = 0; m_hi = '0; m_hq = '0;
    end else if (wr) begin
      if (m_st == 0) begin
        m_st = sq ? 2 : 1;
        if (sq) m_hq = d; else m_hi = d;
      end else if (m_st == 1) begin
        if (sq) begin e_vld = 1; e_i = m_hi; e_q = d; m_hq = d; m_st = 0; end
        else    begin e_err = 1; m_hi = d; end
      end else begin
        if (!sq) begin e_vld = 1; e_i = d; e_q = m_hq; m_hi = d; m_st = 0; end
        else     begin e_err = 1; m_hq = d; end
      end
    end
  endtask

  task automatic step(input string tag, input bit slp, input bit wr, input bit sq,
                      input logic [DW-1:0] d);
    sleep_rst = slp; wr_en = wr; sel_q = sq; din = d;
    @(posedge clk);
    model(slp, wr, sq, d);
    #1;
    chk(tag, "pair_vld", int'(pair_vld), int'(e_vld));
    chk(tag, "dup_err",  int'(dup_err),  int'(e_err));
    chk(tag, "i_out",    int'(i_out),    int'(e_i));
    chk(tag, "q_out",    int'(q_out),    int'(e_q));
  endtask

  initial begin
    #(5 * 100000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_st = 0; m_hi = '0; m_hq = '0; e_i = '0; e_q = '0;
    rst_n = 0; sleep_rst = 0; wr_en = 0; sel_q = 0; din = '0;
    repeat (4) @(posedge clk);
    #1;
    chk("R1", "pair_vld in reset", int'(pair_vld), 0);
    chk("R1", "i_out in reset", int'(i_out), 0);
    rst_n = 1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "dup_err after reset", int'(dup_err), 0);
    chk("R1", "q_out after reset", int'(q_out), 0);

    // R2/R3: I first, then Q, then one quiet cycle
    step("R2", 0, 1, 0, 10'h155);
    step("R3", 0, 1, 1, 10'h2AA);
    step("R3", 0, 0, 0, 10'h000);
    // R2: Q first, then I
    step("R2", 0, 1, 1, 10'h0F0);
    step("R2", 0, 1, 0, 10'h30F);
    // R4: lone word with idle cycles
    step("R4", 0, 1, 0, 10'h111);
    for (int k = 0; k < 6; k++) step("R4", 0, 0, 1, 10'h3FF);
    // R5: overwrite the waiting I word, then complete
    step("R5", 0, 1, 0, 10'h222);
    step("R5", 0, 1, 1, 10'h033);
    // R5: Q repeated, I completes
    step("R5", 0, 1, 1, 10'h001);
    step("R5", 0, 1, 1, 10'h002);
    step("R5", 0, 1, 0, 10'h3FE);
    // R6: strobe low, bus toggles
    step("R6", 0, 1, 0, 10'h0AA);
    for (int k = 0; k < 4; k++) step("R6", 0, 0, k[0], 10'(k * 97));
    step("R6", 0, 1, 1, 10'h055);
    // R7: waiting word dropped by sleep, writes ignored during sleep
    step("R7", 0, 1, 0, 10'h123);
    step("R7", 1, 1, 1, 10'h321);
    step("R7", 1, 1, 0, 10'h0FF);
    step("R7", 0, 1, 1, 10'h2F0);
    step("R7", 0, 1, 0, 10'h10F);
    // R9: strobe tied high, alternating channels
    for (int k = 0; k < 12; k++) step("R9", 0, 1, k[0], 10'(k * 61 + 5));
    // R8: random traffic; lane hold checked every step
    for (int k = 0; k < 600; k++) begin
      bit          s = ($urandom % 20) == 0;
      bit          w = ($urandom % 10) < 7;
      bit          q = $urandom % 2;
      logic [DW-1:0] d = DW'($urandom);
      step("R8", s, w, q, d);
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule